// File: doc/BRIEF.md
# Print engine command/status serial link

This block connects a printer controller's processor to the serial command and status pins of a print engine. Software writes a command byte into a register. The block raises command busy and then shifts the byte out on the command data pin under a clock it generates itself. When the engine wants to report status, it raises status busy. The block answers by generating exactly eight clock pulses and collects the status bits into a status register.

The two directions share one clock pin, so transfers run one at a time. A status request that arrives during a command is held back and served after the command has finished. Two sticky flags tell software that a command has gone out or that a status byte has arrived. Each flag drives its own maskable interrupt. A third flag records command writes that were rejected because a transfer was still running.

Top module: `engine_serial_link`

## Requirements
- R1: After reset the link clock output is high, command busy is low, both interrupts are low, and the status register (address 1) and the flag register (address 2) read as zero. The clock rests high whenever no transfer is running.
- R2: A write to address 0 while the link is idle sends that byte MSB first. The command data output changes only on a falling edge of the link clock, and each bit is presented at the falling edge before the rising edge that takes it. There are exactly eight clock pulses.
- R3: Each clock half-period lasts H system clocks. H is the divider at address 4, and values below 2 count as 2. The first falling edge of a command comes H cycles after the clock edge that accepts the write.
- R4: Command busy is high from the edge that accepts the command write until H cycles after the eighth rising edge. It stays low during status transfers.
- R5: A rising edge on status busy starts a status transfer of exactly eight clocks, but only once it has passed a two-flop synchronizer. The status data input is sampled on each rising clock edge, MSB first. The byte appears at address 1 when the transfer completes.
- R6: Flag register address 2 has bit 0 = command sent, bit 1 = status received and bit 2 = overrun. The flags are sticky. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R7: The command interrupt equals flag bit 0 AND enable bit 0 of address 3. The status interrupt equals flag bit 1 AND enable bit 1 of address 3.
- R8: A write to address 0 while any transfer is running is ignored. The transfer continues unchanged and address 0 keeps the accepted byte, but the overrun flag is set.
- R9: A status request that arrives during a command is held. It is served after the command has completed, and both bytes arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuWrEn | input | 1 | Register write strobe |
| cpuAddr | input | 3 | Register address |
| cpuWrData | input | 8 | Register write data |
| cpuRdData | output | 8 | Register read data, combinational on cpuAddr |
| cmdIrq | output | 1 | Command-sent interrupt |
| stsIrq | output | 1 | Status-received interrupt |
| cmdBusyO | output | 1 | Command busy to the engine |
| cmdClkO | output | 1 | Link clock to the engine, idle high |
| cmdDataO | output | 1 | Serial command data |
| stsBusyI | input | 1 | Status request from the engine (asynchronous) |
| stsDataI | input | 1 | Serial status data |

## Verification
Two functions can fall into the same span of cycles: a command in flight and a status request from the engine. The bench raises status busy a few cycles after a command write and then checks several things. The command byte must arrive bit-exact, sixteen clock pulses must appear in total, and the status byte it supplies must land in the status register. A second overlap pushes a new command write into a running transfer. The bench then checks that the serial byte and the address 0 readback still hold the first command and that the overrun flag is set.

// File: rtl/eslink_pkg.sv
package eslink_pkg;
  localparam int BYTE_W    = 8;
  localparam int PH_W      = 5;
  localparam int HALF_LAST = 2 * BYTE_W;   // index of the trailing high half

  localparam logic [2:0] ADDR_CMD  = 3'd0;
  localparam logic [2:0] ADDR_STS  = 3'd1;
  localparam logic [2:0] ADDR_FLAG = 3'd2;
  localparam logic [2:0] ADDR_IEN  = 3'd3;
  localparam logic [2:0] ADDR_DIV  = 3'd4;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_STS  = 2'd2
  } xferMode_e;

  typedef struct packed {
    logic loadCmd;
    logic rejectCmd;
    logic shiftOut;
    logic sampleIn;
    logic doneCmd;
    logic doneSts;
  } linkStrobe_t;
endpackage

// File: rtl/eslink_ctrl.sv
module eslink_ctrl
  import eslink_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrReq,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             stsBusyI,
  output linkStrobe_t      stb,
  output logic             cmdClkO,
  output logic             cmdBusyO
);
  localparam logic [PH_W-1:0] PH_END = PH_W'(HALF_LAST);

  xferMode_e        mode;
  logic [PH_W-1:0]  ph;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] hLat;
  logic [DIV_W-1:0] effH;
  logic             sync1, sync2, sync3, stsPend;
  logic             reqEdge, idle, tick, startSts;

  // Effective half-period, never below two cycles
  assign effH     = (halfDiv < DIV_W'(2)) ? DIV_W'(2) : halfDiv;
  assign reqEdge  = sync2 & ~sync3;
  assign idle     = (mode == MODE_IDLE);
  assign tick     = !idle && (cnt == '0);
  assign startSts = idle && !cmdWrReq && (stsPend || reqEdge);

  always_comb begin
    stb           = '0;
    stb.loadCmd   = idle && cmdWrReq;
    stb.rejectCmd = !idle && cmdWrReq;
    stb.shiftOut  = tick && (mode == MODE_CMD) && !ph[0] && (ph != PH_END);
    stb.sampleIn  = tick && (mode == MODE_STS) && ph[0];
    stb.doneCmd   = tick && (mode == MODE_CMD) && (ph == PH_END);
    stb.doneSts   = tick && (mode == MODE_STS) && (ph == PH_END);
  end

  assign cmdClkO  = !(!idle && ph[0]);
  assign cmdBusyO = (mode == MODE_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= stsBusyI;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsPend <= 1'b0;
    end else if (startSts) begin
      stsPend <= 1'b0;
    end else if (reqEdge) begin
      stsPend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_IDLE;
      ph   <= '0;
      cnt  <= '0;
      hLat <= DIV_W'(2);
    end else if (stb.loadCmd || startSts) begin
      mode <= stb.loadCmd ? MODE_CMD : MODE_STS;
      ph   <= '0;
      cnt  <= effH - 1'b1;
      hLat <= effH;
    end else if (tick) begin
      if (ph == PH_END) begin
        mode <= MODE_IDLE;
      end else begin
        ph  <= ph + 1'b1;
        cnt <= hLat - 1'b1;
      end
    end else if (!idle) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Each low and high half spans at least two system cycles
  p_low_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdClkO) |=> !cmdClkO);
  p_high_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdClkO) |=> cmdClkO);
  // A status transfer never follows a command without passing idle
  p_sts_waits_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_CMD) |=> (mode != MODE_STS));
endmodule

// File: rtl/eslink_dp.sv
module eslink_dp
  import eslink_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobe_t       stb,
  input  logic              cpuWrEn,
  input  logic [2:0]        cpuAddr,
  input  logic [BYTE_W-1:0] cpuWrData,
  input  logic              stsDataI,
  output logic              cmdDataO,
  output logic [BYTE_W-1:0] cpuRdData,
  output logic [DIV_W-1:0]  halfDiv,
  output logic              cmdIrq,
  output logic              stsIrq
);
  logic [BYTE_W-1:0] cmdReg, stsReg, txSh, rxSh;
  logic [2:0]        flagQ, flagSet, flagClr;
  logic [1:0]        irqEn;
  logic [DIV_W-1:0]  divReg;
  logic              dataQ;

  assign flagSet = {stb.rejectCmd, stb.doneSts, stb.doneCmd};
  assign flagClr = (cpuWrEn && cpuAddr == ADDR_FLAG) ? cpuWrData[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      txSh   <= '0;
      dataQ  <= 1'b0;
    end else if (stb.loadCmd) begin
      cmdReg <= cpuWrData;
      txSh   <= cpuWrData;
    end else if (stb.shiftOut) begin
      dataQ <= txSh[BYTE_W-1];
      txSh  <= {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh   <= '0;
      stsReg <= '0;
    end else begin
      if (stb.sampleIn) rxSh <= {rxSh[BYTE_W-2:0], stsDataI};
      if (stb.doneSts)  stsReg <= rxSh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      irqEn  <= '0;
      divReg <= DIV_W'(DIV_RST);
    end else begin
      flagQ <= (flagQ & ~flagClr) | flagSet;
      if (cpuWrEn && cpuAddr == ADDR_IEN) irqEn  <= cpuWrData[1:0];
      if (cpuWrEn && cpuAddr == ADDR_DIV) divReg <= cpuWrData[DIV_W-1:0];
    end
  end

  always_comb begin
    case (cpuAddr)
      ADDR_CMD:  cpuRdData = cmdReg;
      ADDR_STS:  cpuRdData = stsReg;
      ADDR_FLAG: cpuRdData = {{(BYTE_W-3){1'b0}}, flagQ};
      ADDR_IEN:  cpuRdData = {{(BYTE_W-2){1'b0}}, irqEn};
      ADDR_DIV:  cpuRdData = BYTE_W'(divReg);
      default:   cpuRdData = '0;
    endcase
  end

  assign cmdDataO = dataQ;
  assign halfDiv  = divReg;
  assign cmdIrq   = flagQ[0] & irqEn[0];
  assign stsIrq   = flagQ[1] & irqEn[1];

  p_ignore_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rejectCmd |=> $stable(cmdReg));
  p_cmd_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.doneCmd |=> flagQ[0]);
  p_sts_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.doneSts |=> flagQ[1]);
endmodule

// File: rtl/engine_serial_link.sv
module engine_serial_link
  import eslink_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic [2:0] cpuAddr,
  input  logic [7:0] cpuWrData,
  output logic [7:0] cpuRdData,
  output logic       cmdIrq,
  output logic       stsIrq,
  output logic       cmdBusyO,
  output logic       cmdClkO,
  output logic       cmdDataO,
  input  logic       stsBusyI,
  input  logic       stsDataI
);
  linkStrobe_t      stb;
  logic [DIV_W-1:0] halfDiv;
  logic             cmdWrReq;

  assign cmdWrReq = cpuWrEn && (cpuAddr == ADDR_CMD);

  eslink_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrReq (cmdWrReq),
    .halfDiv  (halfDiv),
    .stsBusyI (stsBusyI),
    .stb      (stb),
    .cmdClkO  (cmdClkO),
    .cmdBusyO (cmdBusyO)
  );

  eslink_dp #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cpuWrEn   (cpuWrEn),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .stsDataI  (stsDataI),
    .cmdDataO  (cmdDataO),
    .cpuRdData (cpuRdData),
    .halfDiv   (halfDiv),
    .cmdIrq    (cmdIrq),
    .stsIrq    (stsIrq)
  );

  // Command data moves only together with a falling link clock
  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdDataO) |-> $fell(cmdClkO));
endmodule

// File: tb/engine_serial_link_tb.sv
module engine_serial_link_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic [2:0] cpuAddr = 3'd0;
  logic [7:0] cpuWrData = 8'd0;
  logic [7:0] cpuRdData;
  logic       cmdIrq, stsIrq, cmdBusyO, cmdClkO, cmdDataO;
  logic       stsBusyI = 1'b0;
  logic       stsDataI = 1'b0;

  int  nChecks = 0;
  int  nFails = 0;
  bit  doneFlag = 0;

  // Results of the most recent watched transfer
  logic [7:0] capByte;
  int rises, falls, lowBad, intraOk, firstFall, busyGap, busySeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  engine_serial_link u_dut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cmdIrq(cmdIrq),
    .stsIrq(stsIrq), .cmdBusyO(cmdBusyO), .cmdClkO(cmdClkO),
    .cmdDataO(cmdDataO), .stsBusyI(stsBusyI), .stsDataI(stsDataI)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = a; cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output int v);
    cpuAddr = a;
    #1;
    v = int'(cpuRdData);
  endtask

  // Engine model and pin monitor; sample n=0 is the negedge right after
  // the accepting edge when called directly after regWr.
  task automatic watch(input int h, input int window, input logic [7:0] stsByte,
                       input int stsReqAt, input int owAt);
    logic prevClk, prevBusy;
    int lastFall, lastRise;
    prevClk = 1'b1; prevBusy = cmdBusyO;
    lastFall = -1; lastRise = -1;
    capByte = 8'd0; rises = 0; falls = 0; lowBad = 0; intraOk = 0;
    firstFall = -1; busyGap = -1; busySeen = 0;
    for (int n = 0; n < window; n++) begin
      if (n == stsReqAt) stsBusyI = 1'b1;
      if (n == owAt) begin cpuWrEn = 1'b1; cpuAddr = 3'd0; cpuWrData = 8'hFF; end
      if (n == owAt + 1) cpuWrEn = 1'b0;
      if (cmdBusyO) busySeen++;
      if (prevClk && !cmdClkO) begin
        if (firstFall < 0) firstFall = n;
        if (lastRise >= 0 && n - lastRise == h) intraOk++;
        stsDataI = stsByte[7 - (falls % 8)];
        falls++;
        lastFall = n;
      end
      if (!prevClk && cmdClkO) begin
        if (n - lastFall != h) lowBad++;
        if (rises < 8) capByte = {capByte[6:0], cmdDataO};
        rises++;
        lastRise = n;
      end
      if (prevBusy && !cmdBusyO && busyGap < 0) busyGap = n - lastRise;
      prevClk = cmdClkO; prevBusy = cmdBusyO;
      @(negedge clk);
    end
  endtask

  task automatic cmdCase(input logic [7:0] b, input int h);
    int v;
    regWr(3'd0, b);
    watch(h, 17*h + 4, 8'h00, -1, -1);
    chk("R2 byte", int'(capByte), int'(b));
    chk("R2 pulses", rises, 8);
    chk("R3 first fall", firstFall, h);
    chk("R3 low widths", lowBad, 0);
    chk("R3 high widths", intraOk, 7);
    chk("R4 busy tail", busyGap, h);
    regRd(3'd2, v);
    chk("R6 sent flag", v, 1);
    chk("R7 cmd irq", int'(cmdIrq), 1);
    regWr(3'd2, 8'h01);
    regRd(3'd2, v);
    chk("R6 w1c", v, 0);
  endtask

  initial begin
    int v, h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk idle high", int'(cmdClkO), 1);
    chk("R1 busy low", int'(cmdBusyO), 0);
    chk("R1 irqs low", int'(cmdIrq) + int'(stsIrq), 0);
    regRd(3'd1, v); chk("R1 status reg", v, 0);
    regRd(3'd2, v); chk("R1 flags", v, 0);

    regWr(3'd3, 8'h03);
    regWr(3'd4, 8'd2);
    for (int b = 0; b < 256; b++) cmdCase(8'(b), 2);

    // R3 divider sweep including values clamped to 2
    for (int d = 0; d < 7; d++) begin
      regWr(3'd4, 8'(d));
      h = (d < 2) ? 2 : d;
      cmdCase(8'hA5, h);
      chk("R1 clk high after", int'(cmdClkO), 1);
    end
    regWr(3'd4, 8'd2);

    // R5 status sweep
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      watch(2, 17*2 + 10, 8'(b), 0, -1);
      chk("R5 pulses", rises, 8);
      chk("R4 no busy in status", busySeen, 0);
      chk("R5 low widths", lowBad, 0);
      regRd(3'd1, v); chk("R5 status byte", v, b);
      regRd(3'd2, v); chk("R6 rcvd flag", v, 2);
      chk("R7 sts irq", int'(stsIrq), 1);
      stsBusyI = 1'b0;
      regWr(3'd2, 8'h02);
      repeat (4) @(negedge clk);
    end

    // R7 masking and R6 selective clear
    regWr(3'd3, 8'h00);
    regWr(3'd0, 8'h11);
    watch(2, 38, 8'h00, -1, -1);
    chk("R7 masked cmd irq", int'(cmdIrq), 0);
    @(negedge clk);
    watch(2, 44, 8'hC3, 0, -1);
    stsBusyI = 1'b0;
    chk("R7 masked sts irq", int'(stsIrq), 0);
    regRd(3'd2, v); chk("R6 both flags", v, 3);
    regWr(3'd3, 8'h02);
    chk("R7 sts irq enabled", int'(stsIrq), 1);
    chk("R7 cmd irq still off", int'(cmdIrq), 0);
    regWr(3'd2, 8'h01);
    regRd(3'd2, v); chk("R6 clear one", v, 2);
    regWr(3'd2, 8'h00);
    regRd(3'd2, v); chk("R6 zero write keeps", v, 2);
    regWr(3'd2, 8'h07);
    repeat (4) @(negedge clk);

    // R8 overrun during a command
    regWr(3'd0, 8'h3C);
    watch(2, 38, 8'h00, -1, 5);
    chk("R8 byte kept on wire", int'(capByte), 8'h3C);
    chk("R8 pulses", rises, 8);
    regRd(3'd0, v); chk("R8 readback", v, 8'h3C);
    regRd(3'd2, v); chk("R8 overrun flag", v, 5);
    regWr(3'd2, 8'h07);

    // R9 status request during a command
    regWr(3'd0, 8'h96);
    watch(2, 17*4 + 20, 8'h5B, 6, -1);
    stsBusyI = 1'b0;
    chk("R9 cmd byte", int'(capByte), 8'h96);
    chk("R9 total pulses", rises, 16);
    regRd(3'd1, v); chk("R9 status byte", v, 8'h5B);
    regRd(3'd2, v); chk("R9 both flags", v, 3);
    chk("R1 clk idle at end", int'(cmdClkO), 1);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!doneFlag) begin
      doneFlag = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule